// File: doc/BRIEF.md
# Burst-Readable FIFO Read Window

This block is a memory-mapped read slave that exposes an internal FIFO as a window of consecutive word addresses. A bursting master increments its address every beat. Every address inside the window is an alias of the FIFO head, so such a master can drain the FIFO with full-speed bursts instead of single reads to one fixed location. A separate push port fills the FIFO from the producing logic.

The slave takes a read command with a start address and a beat count. Inside the window, the command is held with waitrequest until the FIFO holds enough words for the whole burst. After acceptance, one word per cycle is returned with readdatavalid, and each returned word pops one entry. A status address outside the window reports the fill level and a sticky overflow flag without popping. Any other address is accepted and answers zero.

Top module: `burst_fifo_window`

## Requirements
- R1: After reset the FIFO is empty, the overflow flag is clear, readdatavalid is low, and a status read returns zero.
- R2: A read whose word address lies in [WIN_BASE, WIN_BASE+MAX_BURST) returns the oldest FIFO word, whatever the low address bits are, and words leave in push order.
- R3: A window read accepted with burstcount N (a count of zero counts as one) returns exactly N beats on consecutive cycles. The first beat comes the cycle after the accepting edge, each beat raises readdatavalid for one cycle, and each beat pops one entry.
- R4: A window read with fewer than N stored words is held with waitrequest high. It returns no data and pops nothing, and it is accepted once the fill level reaches N.
- R5: While a burst is still returning beats, any new read command is held with waitrequest high.
- R6: A read of STAT_ADDR returns the fill level in bits [LVL_W-1:0] and the overflow flag in bit DATA_W-1 (zeros elsewhere), one cycle after acceptance, and pops nothing.
- R7: A push while the FIFO holds DEPTH words is dropped and sets the overflow flag, which stays set until reset.
- R8: A read to an address outside the window and other than STAT_ADDR is accepted at once, returns zero in one beat and pops nothing.
- R9: A push and a pop in the same cycle leave the fill level unchanged and lose no word.
- R10: With default parameters, a 1024-beat burst is accepted from a FIFO holding 1024 words and drains it completely in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push one word into the FIFO this cycle |
| push_data | input | DATA_W | Word to push |
| av_address | input | ADDR_W | Word address of the read command |
| av_read | input | 1 | Read command present |
| av_burstcount | input | BC_W | Beats requested (0 counts as 1) |
| av_waitrequest | output | 1 | Command not accepted this cycle |
| av_readdata | output | DATA_W | Returned word |
| av_readdatavalid | output | 1 | av_readdata carries a beat |

## Verification
The main read path is driven with single reads and bursts of several lengths. The start addresses lie at the bottom, the middle and the top of the window, so an address decode that used the low bits, or a mis-counted beat, shows up as a wrong word or an extra or missing beat. Bursts requested before enough data exists, commands issued while a burst is still running, and pushes that overlap pops separate the stall logic from the level accounting. A completely full FIFO drained by a maximum burst, followed by status reads, covers the full boundary and the sticky overflow flag.

// File: rtl/burst_fifo_pkg.sv
package burst_fifo_pkg;
   // Which target a read command decodes to
   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_WIN  = 2'd1,
      TGT_STAT = 2'd2
   } tgt_e;
endpackage

// File: rtl/burst_fifo_store.sv
module burst_fifo_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 1024,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic [DATA_W-1:0] push_din,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              overflow
);
   localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              push_ok;

   assign full    = (level == LVL_W'(DEPTH));
   assign push_ok = push_req && !full;
   assign head    = mem[rd_ptr];

   generate
      if (POW2) begin : g_wrap_free
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         level    <= '0;
         overflow <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop)     rd_ptr <= rd_nxt;
         level <= level + LVL_W'(push_ok) - LVL_W'(pop);
         if (push_req && full) overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/burst_fifo_decode.sv
module burst_fifo_decode
   import burst_fifo_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int MAX_BURST = 1024,
   parameter int WIN_BASE  = 0,
   parameter int STAT_ADDR = 1024
) (
   input  logic [ADDR_W-1:0] address,
   output tgt_e              tgt
);
   localparam int WIN_LG = $clog2(MAX_BURST);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);
   localparam logic [ADDR_W-1:0] STAT_V = ADDR_W'(STAT_ADDR);

   logic in_win;
   assign in_win = (address >> WIN_LG) == (BASE_V >> WIN_LG);

   always_comb begin
      if (in_win)                tgt = TGT_WIN;
      else if (address == STAT_V) tgt = TGT_STAT;
      else                        tgt = TGT_NONE;
   end
endmodule

// File: rtl/burst_fifo_beats.sv
module burst_fifo_beats
   import burst_fifo_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int BC_W   = 11,
   parameter int LVL_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant,
   input  tgt_e              tgt,
   input  logic [BC_W-1:0]   bc_eff,
   input  logic [DATA_W-1:0] head,
   input  logic [LVL_W-1:0]  level,
   input  logic              overflow,
   output logic              pop,
   output logic              busy,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   logic [BC_W-1:0]   remain;
   logic [DATA_W-1:0] status_w;

   assign busy = (remain != '0);
   assign pop  = busy || (grant && tgt == TGT_WIN);

   always_comb begin
      status_w              = '0;
      status_w[LVL_W-1:0]   = level;
      status_w[DATA_W-1]    = overflow;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= 1'b0;
         if (busy) begin
            rvalid <= 1'b1;
            rdata  <= head;
            remain <= remain - 1'b1;
         end else if (grant) begin
            rvalid <= 1'b1;
            case (tgt)
               TGT_WIN: begin
                  rdata  <= head;
                  remain <= bc_eff - 1'b1;
               end
               TGT_STAT: rdata <= status_w;
               default:  rdata <= '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/burst_fifo_window.sv
module burst_fifo_window
   import burst_fifo_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 12,
   parameter int MAX_BURST = 1024,
   parameter int DEPTH     = 1024,
   parameter int WIN_BASE  = 0,
   parameter int STAT_ADDR = 1024,
   localparam int BC_W     = $clog2(MAX_BURST) + 1,
   localparam int LVL_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic [ADDR_W-1:0] av_address,
   input  logic              av_read,
   input  logic [BC_W-1:0]   av_burstcount,
   output logic              av_waitrequest,
   output logic [DATA_W-1:0] av_readdata,
   output logic              av_readdatavalid
);
   // Elaboration-time parameter checks
   generate
      if ((MAX_BURST & (MAX_BURST - 1)) != 0) begin : g_bad_burst
         $error("MAX_BURST must be a power of two");
      end
      if (DEPTH < MAX_BURST) begin : g_bad_depth
         $error("DEPTH must hold at least one maximum burst");
      end
      if ((WIN_BASE % MAX_BURST) != 0) begin : g_bad_base
         $error("WIN_BASE must be aligned to MAX_BURST");
      end
      if (STAT_ADDR >= WIN_BASE && STAT_ADDR < WIN_BASE + MAX_BURST) begin : g_bad_stat
         $error("STAT_ADDR must lie outside the window");
      end
      if (LVL_W >= DATA_W) begin : g_bad_lvl
         $error("fill level does not fit below the overflow bit");
      end
      if ($clog2(MAX_BURST) >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the window and status address");
      end
   endgenerate

   tgt_e              tgt;
   logic [BC_W-1:0]   bc_eff;
   logic [DATA_W-1:0] head;
   logic [LVL_W-1:0]  lvl;
   logic              full, overflow, pop, busy, grant, short_fifo;

   assign bc_eff     = (av_burstcount == '0) ? BC_W'(1) : av_burstcount;
   assign short_fifo = (tgt == TGT_WIN) && (32'(lvl) < 32'(bc_eff));
   assign av_waitrequest = busy || (av_read && short_fifo);
   assign grant      = av_read && !av_waitrequest;

   burst_fifo_decode #(
      .ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST),
      .WIN_BASE(WIN_BASE), .STAT_ADDR(STAT_ADDR)
   ) u_decode (
      .address(av_address),
      .tgt    (tgt)
   );

   burst_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_req(push_valid),
      .push_din(push_data),
      .pop     (pop),
      .head    (head),
      .level   (lvl),
      .full    (full),
      .overflow(overflow)
   );

   burst_fifo_beats #(.DATA_W(DATA_W), .BC_W(BC_W), .LVL_W(LVL_W)) u_beats (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant   (grant),
      .tgt     (tgt),
      .bc_eff  (bc_eff),
      .head    (head),
      .level   (lvl),
      .overflow(overflow),
      .pop     (pop),
      .busy    (busy),
      .rdata   (av_readdata),
      .rvalid  (av_readdatavalid)
   );
endmodule

// File: rtl/burst_fifo_window_chk.sv
module burst_fifo_window_chk
   import burst_fifo_pkg::*;
#(
   parameter int BC_W  = 11,
   parameter int LVL_W = 11
) (
   input logic            clk,
   input logic            rst_n,
   input logic            av_read,
   input logic            av_waitrequest,
   input logic            av_readdatavalid,
   input tgt_e            tgt,
   input logic [BC_W-1:0] bc_eff,
   input logic [LVL_W-1:0] lvl,
   input logic            busy,
   input logic            pop,
   input logic            push_valid,
   input logic            full,
   input logic            overflow
);
   // R4: a window command is only granted when the whole burst is stored
   a_r4_grant_has_words: assert property (@(posedge clk) disable iff (!rst_n)
      (av_read && !av_waitrequest && tgt == TGT_WIN) |-> (32'(lvl) >= 32'(bc_eff)));

   // R5: no command is taken while beats are still being returned
   a_r5_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> av_waitrequest);

   // R3: every pop produces a valid beat on the next cycle
   a_r3_pop_gives_beat: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> av_readdatavalid);

   // R6: a granted status read never pops
   a_r6_status_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (av_read && !av_waitrequest && tgt == TGT_STAT) |-> !pop);

   // R7: overflow flag is sticky
   a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R7: a push into a full FIFO does not change the level
   a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && full && !pop) |=> (lvl == $past(lvl)));

   // R9: simultaneous push and pop keep the level
   a_r9_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
      (push_valid && !full && pop) |=> (lvl == $past(lvl)));
endmodule

bind burst_fifo_window burst_fifo_window_chk #(.BC_W(BC_W), .LVL_W(LVL_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .av_read         (av_read),
   .av_waitrequest  (av_waitrequest),
   .av_readdatavalid(av_readdatavalid),
   .tgt             (tgt),
   .bc_eff          (bc_eff),
   .lvl             (lvl),
   .busy            (busy),
   .pop             (pop),
   .push_valid      (push_valid),
   .full            (full),
   .overflow        (overflow)
);

// File: tb/burst_fifo_window_tb_top.sv
`timescale 1ns/1ps
module burst_fifo_window_tb_top;
   localparam int DW = 32, AW = 12, MB = 1024, DEP = 1024, BCW = 11;
   localparam logic [AW-1:0] STAT  = 12'h400;
   localparam logic [AW-1:0] OTHER = 12'h800;

   // Vector table: {start address offset in window, burstcount}
   localparam int NV = 8;
   localparam logic [23:0] VEC [NV] = '{
      {12'd0,    12'd1},
      {12'd1023, 12'd1},
      {12'd512,  12'd4},
      {12'd3,    12'd16},
      {12'd0,    12'd64},
      {12'd1000, 12'd7},
      {12'd77,   12'd0},
      {12'd255,  12'd33}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push_valid = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic [AW-1:0] av_address = '0;
   logic av_read = 1'b0;
   logic [BCW-1:0] av_burstcount = '0;
   logic av_waitrequest;
   logic [DW-1:0] av_readdata;
   logic av_readdatavalid;

   always #2.5 clk = ~clk;

   burst_fifo_window dut_i (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_data(push_data),
      .av_address(av_address), .av_read(av_read), .av_burstcount(av_burstcount),
      .av_waitrequest(av_waitrequest), .av_readdata(av_readdata),
      .av_readdatavalid(av_readdatavalid)
   );

   int n_chk = 0, n_err = 0;
   int wr_seq = 0, rd_seq = 0, m_lvl = 0;
   bit m_ovf = 1'b0;
   bit done = 1'b0;

   function automatic logic [31:0] pat(int s);
      return {16'(s) ^ 16'h5A5A, 16'(s)};
   endfunction

   function automatic logic [31:0] stat_exp();
      return {m_ovf, 20'd0, 11'(m_lvl)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push_one();
      @(negedge clk);
      push_valid = 1'b1;
      if (m_lvl < DEP) begin
         push_data = pat(wr_seq);
         wr_seq++;
         m_lvl++;
      end else begin
         push_data = 32'hDEAD_BEEF;
         m_ovf = 1'b1;
      end
      @(posedge clk);
      #1 push_valid = 1'b0;
   endtask

   // kind 0: window burst, kind 1: single read with expected value exp1
   task automatic bus_read(input logic [AW-1:0] a, input int n, input int kind,
                           input logic [31:0] exp1, input string req);
      int w = 0;
      int beats;
      beats = (kind == 0) ? ((n == 0) ? 1 : n) : 1;
      @(negedge clk);
      av_read = 1'b1; av_address = a; av_burstcount = BCW'(n);
      #1;
      while (av_waitrequest && w < 20000) begin
         @(negedge clk); #1; w++;
      end
      @(negedge clk);
      av_read = 1'b0;
      for (int k = 0; k < beats; k++) begin
         if (k > 0) @(negedge clk);
         if (kind == 0) begin
            chk(av_readdatavalid && av_readdata == pat(rd_seq), req, av_readdata, pat(rd_seq));
            rd_seq++;
            m_lvl--;
         end else begin
            chk(av_readdatavalid && av_readdata == exp1, req, av_readdata, exp1);
         end
      end
      @(negedge clk);
      chk(!av_readdatavalid, {req, " no extra beat"}, 32'(av_readdatavalid), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!av_readdatavalid && !av_waitrequest, "R1 outputs in reset",
          {30'd0, av_readdatavalid, av_waitrequest}, 32'd0);
      rst_n = 1'b1;
      bus_read(STAT, 1, 1, 32'd0, "R1 status after reset");

      // R2/R3: table walk of bursts at varied window addresses
      for (int v = 0; v < NV; v++) begin
         int nb;
         nb = (VEC[v][11:0] == 0) ? 1 : int'(VEC[v][11:0]);
         for (int p = 0; p < nb; p++) push_one();
         bus_read(VEC[v][23:12], int'(VEC[v][11:0]), 0, 32'd0, "R2 R3 window burst");
         bus_read(STAT, 1, 1, stat_exp(), "R3 level after burst");
      end

      // R4: burst held until enough words are stored
      for (int p = 0; p < 3; p++) push_one();
      fork
         bus_read(12'd9, 5, 0, 32'd0, "R4 burst after stall");
         begin
            repeat (3) begin
               @(negedge clk); #2;
               chk(av_waitrequest && !av_readdatavalid, "R4 held while short",
                   {30'd0, av_waitrequest, av_readdatavalid}, 32'd2);
            end
            push_one();
            push_one();
         end
      join
      bus_read(STAT, 1, 1, stat_exp(), "R4 level after stalled burst");

      // R5: new command held while beats are returned
      for (int p = 0; p < 6; p++) push_one();
      @(negedge clk);
      av_read = 1'b1; av_address = 12'd5; av_burstcount = BCW'(4);
      #1;
      chk(!av_waitrequest, "R5 burst accepted", 32'(av_waitrequest), 32'd0);
      @(negedge clk);
      av_address = STAT; av_burstcount = BCW'(1);
      #1;
      for (int k = 0; k < 4; k++) begin
         if (k > 0) begin @(negedge clk); #1; end
         chk(av_readdatavalid && av_readdata == pat(rd_seq), "R5 beat", av_readdata, pat(rd_seq));
         rd_seq++; m_lvl--;
         if (k < 3) chk(av_waitrequest, "R5 command held", 32'(av_waitrequest), 32'd1);
         else       chk(!av_waitrequest, "R5 command released", 32'(av_waitrequest), 32'd0);
      end
      @(negedge clk);
      av_read = 1'b0;
      chk(av_readdatavalid && av_readdata == stat_exp(), "R5 R6 status after burst",
          av_readdata, stat_exp());

      // R6: status reads do not pop
      bus_read(STAT, 1, 1, stat_exp(), "R6 status first");
      bus_read(STAT, 1, 1, stat_exp(), "R6 status repeat");
      bus_read(12'd700, 2, 0, 32'd0, "R6 data intact after status");

      // R8: other addresses answer zero, no pop
      push_one();
      bus_read(OTHER, 1, 1, 32'd0, "R8 other address");
      bus_read(STAT, 1, 1, stat_exp(), "R8 level kept");
      bus_read(12'd1, 1, 0, 32'd0, "R8 word kept");

      // R9: pushes overlapping burst pops
      for (int p = 0; p < 4; p++) push_one();
      fork
         bus_read(12'd64, 4, 0, 32'd0, "R9 burst with pushes");
         begin
            push_one(); push_one(); push_one();
         end
      join
      bus_read(STAT, 1, 1, stat_exp(), "R9 level after overlap");
      bus_read(12'd300, 3, 0, 32'd0, "R9 pushed words kept");

      // R7/R10: fill, overflow, drain with maximum burst
      for (int p = 0; p < DEP; p++) push_one();
      bus_read(STAT, 1, 1, 32'h0000_0400, "R10 full level");
      push_one();
      bus_read(STAT, 1, 1, 32'h8000_0400, "R7 overflow set, level kept");
      bus_read(12'd0, 0 + MB, 0, 32'd0, "R10 max burst");
      bus_read(STAT, 1, 1, 32'h8000_0000, "R7 overflow sticky, empty");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule